// File: doc/BRIEF.md
# Clock Synthesizer Program Word Encoder

This block turns a requested pixel clock, given in units of 0.01 MHz, into the 15-bit program word that a serially loaded clock synthesizer expects. First the request is limited to the top of the legal range. Requests too slow to synthesize at all give a word that carries only the stop bits. Any other request is doubled until it reaches the oscillator range, and each doubling also doubles the post-divider. The post-divider code, the rounded feedback count (less a fixed offset) and the stop bits are then packed into one word.

A caller pulses `start_i` with the request on `req_i`. The block is busy for several dozen cycles while a single iterative restoring divider runs twice: once for the reference ratio and once for rounding. The block then raises `done_o` for one cycle. The word and the chosen post-divider stay on the outputs until the next result.

Top module: `pw_encoder`

## Requirements
- R1: A request above 15938 is treated as exactly 15938. Any value above that limit gives the same word as 15938.
- R2: A request below 1000 gives a word of 0x1800: a feedback field of 0, a post-divider code of 0 and the stop bits. In this case `div_o` is 1.
- R3: While the working value is below 8000 it is doubled and the post-divider is doubled. The post-divider starts at 1 and `div_o` reports 1, 2, 4 or 8.
- R4: The feedback count is floor((floor(f*46000/1432)+500)/1000), where f is the working value after doubling. Word bits 8:0 hold this count minus 257.
- R5: Word bits 10:9 hold the post-divider code: 0 for divide-by-1, 1 for divide-by-2, 2 for divide-by-4 and 3 for divide-by-8.
- R6: Word bits 12:11 are always 1 (the stop bits) and bits 14:13 are always 0.
- R7: `done_o` is high for exactly one cycle per accepted request. `word_o` and `div_o` change only in that cycle and hold their value between results.
- R8: While `busy_o` is high, `start_i` is ignored. The result and the number of `done_o` pulses belong to the request already accepted.
- R9: After reset, `done_o` and `busy_o` are 0 and `word_o` and `div_o` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request strobe, taken only when idle |
| req_i | input | 16 | Requested frequency in 0.01 MHz |
| busy_o | output | 1 | Calculation in progress |
| done_o | output | 1 | One-cycle result strobe |
| word_o | output | 15 | Program word |
| div_o | output | 4 | Chosen post-divider (1, 2, 4, 8) |

## Verification
The bench covers both edges of the doubling search. At 1000 the search must stop at divide-by-8 with a feedback field of 0; a loop that stopped one step early or late would give a wrong code or an underflowed field. It also covers 999 against 1000 and 15938 against 15939 and above; a wrong comparison would drop a boundary request into the wrong path or let an unclamped value run through. A second start is issued mid-calculation to catch a design that restarts or gives two results. The rounding is exercised at values where the truncated and rounded counts differ, so a design that skips the half-unit addition gives a result one lower.

// File: rtl/pw_pkg.sv
package pw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_NORM,
    ST_DIVA,
    ST_DIVB
  } pw_state_t;

  localparam int FIELD_W  = 9;
  localparam int CODE_LSB = 9;
  localparam int STOP_LSB = 11;
endpackage

// File: rtl/pw_divider.sv
module pw_divider #(
  parameter int W = 30
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         go_i,
  input  logic [W-1:0] num_i,
  input  logic [W-1:0] den_i,
  output logic         fin_o,
  output logic [W-1:0] quo_o
);
  localparam int CW = $clog2(W + 1);

  logic [W:0]   rem_q;
  logic [W-1:0] acc_q;
  logic [W-1:0] den_q;
  logic [CW-1:0] cnt_q;
  logic          run_q;
  logic [W:0]   trial;

  assign trial = {rem_q[W-1:0], acc_q[W-1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q <= '0;
      acc_q <= '0;
      den_q <= '0;
      cnt_q <= '0;
      run_q <= 1'b0;
      fin_o <= 1'b0;
    end else begin
      fin_o <= 1'b0;
      if (go_i) begin
        rem_q <= '0;
        acc_q <= num_i;
        den_q <= den_i;
        cnt_q <= CW'(W);
        run_q <= 1'b1;
      end else if (run_q) begin
        if (trial >= {1'b0, den_q}) begin
          rem_q <= trial - {1'b0, den_q};
          acc_q <= {acc_q[W-2:0], 1'b1};
        end else begin
          rem_q <= trial;
          acc_q <= {acc_q[W-2:0], 1'b0};
        end
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          run_q <= 1'b0;
          fin_o <= 1'b1;
        end
      end
    end
  end

  assign quo_o = acc_q;

  AST_REM_BELOW_DEN: assert property (@(posedge clk) disable iff (rst)
    (run_q && cnt_q != CW'(W)) |-> (rem_q < {1'b0, den_q})); // R4
  AST_RUN_COUNT: assert property (@(posedge clk) disable iff (rst)
    run_q |-> (cnt_q != '0)); // R4
endmodule

// File: rtl/pw_pack.sv
module pw_pack #(
  parameter int DIV_W  = 30,
  parameter int WORD_W = 15,
  parameter int OFFSET = 257
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic             zero_i,
  input  logic [DIV_W-1:0] cnt_i,
  input  logic [1:0]       code_i,
  output logic             done_o,
  output logic [WORD_W-1:0] word_o,
  output logic [3:0]       div_o
);
  import pw_pkg::*;

  logic [DIV_W-1:0]  field_full;
  logic [WORD_W-1:0] word_n;
  logic [1:0]        code_n;

  assign field_full = cnt_i - DIV_W'(OFFSET);
  assign code_n     = zero_i ? 2'd0 : code_i;

  always_comb begin
    word_n = '0;
    word_n[STOP_LSB +: 2] = 2'b11;
    word_n[CODE_LSB +: 2] = code_n;
    if (!zero_i) word_n[FIELD_W-1:0] = field_full[FIELD_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done_o <= 1'b0;
      word_o <= '0;
      div_o  <= '0;
    end else begin
      done_o <= load_i;
      if (load_i) begin
        word_o <= word_n;
        div_o  <= 4'd1 << code_n;
      end
    end
  end

  AST_FIELD_FITS: assert property (@(posedge clk) disable iff (rst)
    (load_i && !zero_i) |-> (field_full[DIV_W-1:FIELD_W] == '0)); // R4
  AST_STOP_BITS: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (word_o[WORD_W-1:STOP_LSB] == 4'b0011)); // R6
  AST_CODE_MATCH: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (div_o == (4'd1 << word_o[CODE_LSB +: 2]))); // R5
  AST_HOLD_OUT: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> ($stable(word_o) && $stable(div_o))); // R7
endmodule

// File: rtl/pw_encoder.sv
module pw_encoder #(
  parameter int REQ_W      = 16,
  parameter int WORD_W     = 15,
  parameter int DIV_W      = 30,
  parameter int REQ_MAX    = 15938,
  parameter int REQ_MIN    = 1000,
  parameter int VCO_MIN    = 8000,
  parameter int REF_MUL    = 46,
  parameter int REF_DIV    = 1432,
  parameter int ROUND_SCL  = 1000,
  parameter int OFFSET     = 257
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [REQ_W-1:0]  req_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [WORD_W-1:0] word_o,
  output logic [3:0]        div_o
);
  import pw_pkg::*;

  localparam logic [DIV_W-1:0] SCALE_K = DIV_W'(REF_MUL * ROUND_SCL);
  localparam logic [DIV_W-1:0] HALF_K  = DIV_W'(ROUND_SCL / 2);

  pw_state_t        st_q;
  logic [REQ_W-1:0] f_q;
  logic [1:0]       shift_q;
  logic             low_req;
  logic [REQ_W-1:0] clamped;
  logic             div_go;
  logic [DIV_W-1:0] div_num;
  logic [DIV_W-1:0] div_den;
  logic             div_fin;
  logic [DIV_W-1:0] div_quo;
  logic             load;

  assign low_req = req_i < REQ_W'(REQ_MIN);
  assign clamped = (req_i > REQ_W'(REQ_MAX)) ? REQ_W'(REQ_MAX) : req_i;
  assign busy_o  = (st_q != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      f_q     <= '0;
      shift_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i && !low_req) begin
          f_q     <= clamped;
          shift_q <= '0;
          st_q    <= ST_NORM;
        end
        ST_NORM: if (f_q < REQ_W'(VCO_MIN)) begin
          f_q     <= f_q << 1;
          shift_q <= shift_q + 2'd1;
        end else begin
          st_q <= ST_DIVA;
        end
        ST_DIVA: if (div_fin) st_q <= ST_DIVB;
        ST_DIVB: if (div_fin) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    div_go  = 1'b0;
    div_num = div_quo + HALF_K;
    div_den = DIV_W'(ROUND_SCL);
    if (st_q == ST_NORM) begin
      div_go  = (f_q >= REQ_W'(VCO_MIN));
      div_num = DIV_W'(f_q) * SCALE_K;
      div_den = DIV_W'(REF_DIV);
    end else if (st_q == ST_DIVA) begin
      div_go = div_fin;
    end
  end

  assign load = (st_q == ST_IDLE && start_i && low_req) ||
                (st_q == ST_DIVB && div_fin);

  pw_divider #(.W(DIV_W)) u_div (
    .clk   (clk),
    .rst   (rst),
    .go_i  (div_go),
    .num_i (div_num),
    .den_i (div_den),
    .fin_o (div_fin),
    .quo_o (div_quo)
  );

  pw_pack #(.DIV_W(DIV_W), .WORD_W(WORD_W), .OFFSET(OFFSET)) u_pack (
    .clk    (clk),
    .rst    (rst),
    .load_i (load),
    .zero_i (st_q == ST_IDLE),
    .cnt_i  (div_quo),
    .code_i (shift_q),
    .done_o (done_o),
    .word_o (word_o),
    .div_o  (div_o)
  );

  AST_CLAMPED: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_NORM && shift_q == 2'd0) |-> (f_q <= REQ_W'(REQ_MAX))); // R1
  AST_VCO_RANGE: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_DIVA) |-> (f_q >= REQ_W'(VCO_MIN) && f_q < REQ_W'(2 * VCO_MIN))); // R3
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
    (busy_o && start_i && st_q != ST_DIVB) |=> !done_o); // R8
endmodule

// File: tb/pw_encoder_tb.sv
module pw_encoder_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [15:0] req_i = '0;
  logic        busy_o, done_o;
  logic [14:0] word_o;
  logic [3:0]  div_o;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;

  always #5 clk = ~clk;

  pw_encoder u_dut (
    .clk(clk), .rst(rst), .start_i(start_i), .req_i(req_i),
    .busy_o(busy_o), .done_o(done_o), .word_o(word_o), .div_o(div_o)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: run hung, got %0d cycles expected < 100000", cyc);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  task automatic check(input string tag, input int got, input int exp);
    n_checks++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  function automatic int ref_word(input int req, output int pd);
    longint f, q, c;
    int code;
    pd = 1; code = 0;
    if (req < 1000) return 32'h1800;
    f = (req > 15938) ? 15938 : req;
    while (f < 8000) begin f = f * 2; pd = pd * 2; code++; end
    q = (f * 46000) / 1432;
    c = (q + 500) / 1000;
    return 32'h1800 | (code << 9) | int'(c - 257);
  endfunction

  task automatic run_req(input int req, input string tag);
    int exp_w, exp_d, waited;
    exp_w = ref_word(req, exp_d);
    @(negedge clk);
    start_i = 1'b1; req_i = 16'(req);
    @(negedge clk);
    start_i = 1'b0;
    waited = 0;
    while (!done_o && waited < 300) begin @(negedge clk); waited++; end
    check({tag, " done"}, int'(done_o), 1);
    check({tag, " word"}, int'(word_o), exp_w);
    check({tag, " div"}, int'(div_o), exp_d);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R9 done", int'(done_o), 0);
    check("R9 busy", int'(busy_o), 0);
    check("R9 word", int'(word_o), 0);
    check("R9 div", int'(div_o), 0);
  endtask

  task automatic t_clamp;
    run_req(15938, "R1 at max");
    run_req(15939, "R1 just above");
    check("R1 word 0x18FF", int'(word_o), 32'h18FF);
    run_req(65535, "R1 far above");
  endtask

  task automatic t_low;
    run_req(999, "R2 999");
    check("R2 word 0x1800", int'(word_o), 32'h1800);
    run_req(0, "R2 zero");
  endtask

  task automatic t_double;
    run_req(1000, "R3 1000 div8");
    check("R5 code3 word 0x1E00", int'(word_o), 32'h1E00);
    run_req(2500, "R3 div4");
    run_req(4000, "R3 div2");
    run_req(7999, "R3 7999 div2");
    run_req(8000, "R3 8000 div1");
    check("R5 code0 word 0x1800", int'(word_o), 32'h1800);
  endtask

  task automatic t_round;
    run_req(12000, "R4 12000");
    run_req(10015, "R4 10015");
    run_req(9000, "R6 9000");
    check("R6 top bits", int'(word_o[14:11]), 3);
  endtask

  task automatic t_pulse_hold;
    int w;
    run_req(5000, "R7 setup");
    w = word_o;
    @(negedge clk);
    check("R7 pulse width", int'(done_o), 0);
    repeat (5) @(negedge clk);
    check("R7 held", int'(word_o), w);
  endtask

  task automatic t_ignore;
    int exp_w, exp_d, pulses;
    exp_w = ref_word(3000, exp_d);
    @(negedge clk);
    start_i = 1'b1; req_i = 16'd3000;
    @(negedge clk);
    start_i = 1'b0;
    check("R8 busy", int'(busy_o), 1);
    repeat (5) @(negedge clk);
    start_i = 1'b1; req_i = 16'd12000;
    @(negedge clk);
    start_i = 1'b1; req_i = 16'd500;
    @(negedge clk);
    start_i = 1'b0;
    pulses = 0;
    for (int i = 0; i < 200; i++) begin
      if (done_o) begin
        pulses++;
        check("R8 word", int'(word_o), exp_w);
        check("R8 div", int'(div_o), exp_d);
      end
      @(negedge clk);
    end
    check("R8 pulse count", pulses, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_clamp();
    t_low();
    t_double();
    t_round();
    t_pulse_hold();
    t_ignore();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule